// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block sits on the target side of a shared 32-bit address/data bus and attaches a small internal store of 64 words to it. An access opens with a single-cycle start strobe while the chip select is low. In that cycle the shared lines carry the target address in their low bits and a three-bit size code in their top bits. The target captures both, because the same lines carry data from the next cycle on. It then serves one or more data beats. Each beat takes two cycles: a wait cycle, then a cycle in which the target raises its ready output and the word moves.

The initiator keeps `frame` high through the access and pulls it low in the first cycle of the final beat. The target does not count beats. It uses that edge alone to close the access, so every size code runs through the same sequence. The target advances the word address itself between beats, in 4-byte steps that wrap inside the aligned 32-byte block. Sub-word writes touch only the byte lanes their address selects. The chip select may stay low across accesses, and a new strobe is taken in the cycle right after a final ready.

The shared lines appear as separate input, output and output-enable ports, and the pad tri-state is left to the surrounding logic.

Top module: `mpxt_target`

## Requirements
- R1: After reset `rdy` and `bus_oe` are 0, `bus_out` is 0, and every one of the 64 stored words reads back as 0.
- R2: A start strobe (`start_n` = 0) is taken only while `cs_n` = 0. Otherwise it has no effect: `rdy` stays 0 and no word changes.
- R3: Each beat lasts two cycles. `rdy` is 0 in the first cycle of a beat and 1 in the second, so there is exactly one wait state.
- R4: Write data present on `bus_in` in a ready cycle is stored in the word selected by address bits 7..2. Address bits above bit 7 are ignored, so addresses that differ only there reach the same word.
- R5: Size code 000 (byte) writes only lane `addr[1:0]`, where lane n is bits 8n+7..8n. Code 001 (word) writes lanes 1..0 when `addr[1]` = 0 and lanes 3..2 when `addr[1]` = 1. Codes 010 (longword), 011 (quadword) and 1xx (32-byte burst) write all four lanes.
- R6: During the ready cycle of a read beat `bus_oe` is 1 and `bus_out` carries the whole addressed word. `bus_oe` is 0 throughout write accesses and in the cycle after the last read ready.
- R7: When `frame` is 0 in the first cycle of a beat, that beat is the last one. After its ready cycle, `rdy` stays 0 until a new strobe arrives, even when the size code would allow more beats.
- R8: A strobe in the cycle right after a final ready cycle, with `cs_n` still low, is accepted and starts a normal access.
- R9: The first beat uses the captured address. Each later beat adds 4 to the address, wrapping inside the aligned 32-byte block, so bits 4..2 count modulo 8 and the other bits stay fixed. A burst of eight beats therefore visits all eight words of the block once.
- R10: A quadword access runs two beats, at the captured address and at the next word of the block under the same wrap rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| start_n | input | 1 | One-cycle start strobe marking the address phase, active low |
| frame | input | 1 | High during an access; low in the first cycle of the final beat |
| dir_wr | input | 1 | Access direction sampled with the strobe: 1 write, 0 read |
| bus_in | input | 32 | Shared lines as seen by the target: size code [31:29] and address [25:0] at the strobe, write data in ready cycles |
| bus_out | output | 32 | Read data, valid in read ready cycles, 0 otherwise |
| bus_oe | output | 1 | High while the target may drive the shared lines (read accesses) |
| rdy | output | 1 | Beat ready, high in the second cycle of each beat |

## Verification
The strobe is captured at the clock edge that ends its cycle. The first cycle of the first beat follows, with `rdy` low and `frame` sampled, and `rdy` and read data appear in the cycle after that. Every later beat repeats this two-cycle pattern. A write becomes visible to a read that starts one cycle after the write's ready cycle, which is the earliest moment a following access can reach it. The bench drives inputs and samples outputs at the falling edge. It checks `rdy` = 0 in each wait cycle, checks `rdy`, `bus_oe` and `bus_out` in each ready cycle against a bench model updated with the same lane rules, and checks that `rdy` and `bus_oe` are 0 in the cycle after the final ready, which is the same cycle in which it places the next strobe.

// File: rtl/mpxt_pkg.sv
// Shared types for the multiplexed bus target.
// Assumes a single clock domain; phase encodings are internal only.
package mpxt_pkg;

    // Access sequencing: idle, first (wait) cycle of a beat, ready cycle of a beat.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_RDY  = 2'd2
    } phase_t;

    // Size codes carried in the top three bits at the strobe.
    localparam logic [2:0] SZ_BYTE = 3'b000;
    localparam logic [2:0] SZ_WORD = 3'b001;

endpackage

// File: rtl/mpxt_phase_ctrl.sv
// Phase controller: captures address, size and direction at the start
// strobe, walks beats as wait/ready pairs, samples frame in each wait
// cycle to spot the final beat, and steps the word address with wrap
// inside the aligned block.
// Assumes the strobe lasts one cycle and that frame is valid in the first
// cycle of every beat.
module mpxt_phase_ctrl #(
    parameter int LOC_W       = 8,
    parameter int BLOCK_BYTES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 start_n,
    input  logic                 frame,
    input  logic                 dir_wr,
    input  logic [LOC_W-1:0]     addr_in,
    input  logic [2:0]           size_in,
    output mpxt_pkg::phase_t     phase,
    output logic [LOC_W-1:0]     addr_q,
    output logic [2:0]           size_q,
    output logic                 wr_q,
    output logic                 last_q
);
    import mpxt_pkg::*;

    localparam int OFF_LO = 2;
    localparam int OFF_HI = $clog2(BLOCK_BYTES) - 1;
    localparam int STEP_W = OFF_HI - OFF_LO + 1;
    localparam logic [STEP_W-1:0] STEP_ONE = 1;

    // Sequence the access and hold the captured request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            addr_q <= '0;
            size_q <= '0;
            wr_q   <= 1'b0;
            last_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (!cs_n && !start_n) begin
                        addr_q <= addr_in;
                        size_q <= size_in;
                        wr_q   <= dir_wr;
                        phase  <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    last_q <= !frame;
                    phase  <= PH_RDY;
                end
                PH_RDY: begin
                    if (last_q) begin
                        phase <= PH_IDLE;
                    end else begin
                        addr_q[OFF_HI:OFF_LO] <= addr_q[OFF_HI:OFF_LO] + STEP_ONE;
                        phase <= PH_WAIT;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mpxt_lane_dec.sv
// Byte-lane decoder: turns the captured size code and the two low address
// bits into a write mask, lane n being bits 8n+7..8n of the word.
// Assumes a four-lane (32-bit) data path.
module mpxt_lane_dec #(
    parameter int LANES = 4
) (
    input  logic [2:0]       size,
    input  logic [1:0]       lo,
    output logic [LANES-1:0] mask
);
    import mpxt_pkg::*;

    localparam logic [LANES-1:0] ONE_LANE  = 1;
    localparam logic [LANES-1:0] LOW_HALF  = {LANES/2{1'b1}};

    // Pick the lanes a write of this size at this offset may touch.
    always_comb begin
        case (size)
            SZ_BYTE: mask = ONE_LANE << lo;
            SZ_WORD: mask = lo[1] ? (LOW_HALF << (LANES/2)) : LOW_HALF;
            default: mask = '1;
        endcase
    end

endmodule

// File: rtl/mpxt_store.sv
// Word store with per-lane write enables and a combinational read port.
// Cleared by reset so read data is defined from the start.
module mpxt_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(DEPTH)-1:0]  idx,
    input  logic [DATA_W/8-1:0]       mask,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise update only the enabled lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (mask[l]) mem[idx][l*8 +: 8] <= wdata[l*8 +: 8];
            end
        end
    end

    // Present the addressed word.
    assign rdata = mem[idx];

endmodule

// File: rtl/mpxt_target.sv
// Target interface for the multiplexed address/data bus. Splits the
// shared lines into address and size at the strobe and data afterwards,
// and ties the phase controller, lane decoder and word store together.
// Assumes the pads combine bus_out/bus_oe into the tri-state lines.
module mpxt_target #(
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 64,
    parameter int BLOCK_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              start_n,
    input  logic              frame,
    input  logic              dir_wr,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              rdy
);
    import mpxt_pkg::*;

    localparam int IDX_W  = $clog2(DEPTH);
    localparam int LOC_W  = IDX_W + 2;
    localparam int SZ_LSB = DATA_W - 3;
    localparam int LANES  = DATA_W / 8;

    phase_t             phase;
    logic [LOC_W-1:0]   addr_q;
    logic [2:0]         size_q;
    logic               wr_q;
    logic               last_q;
    logic [LANES-1:0]   lane_mask;
    logic [DATA_W-1:0]  rdata;

    mpxt_phase_ctrl #(
        .LOC_W       (LOC_W),
        .BLOCK_BYTES (BLOCK_BYTES)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .start_n (start_n),
        .frame   (frame),
        .dir_wr  (dir_wr),
        .addr_in (bus_in[LOC_W-1:0]),
        .size_in (bus_in[SZ_LSB +: 3]),
        .phase   (phase),
        .addr_q  (addr_q),
        .size_q  (size_q),
        .wr_q    (wr_q),
        .last_q  (last_q)
    );

    mpxt_lane_dec #(
        .LANES (LANES)
    ) u_lanes (
        .size (size_q),
        .lo   (addr_q[1:0]),
        .mask (lane_mask)
    );

    mpxt_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (phase == PH_RDY && wr_q),
        .idx   (addr_q[LOC_W-1:2]),
        .mask  (lane_mask),
        .wdata (bus_in),
        .rdata (rdata)
    );

    // Ready marks the second cycle of each beat.
    assign rdy     = (phase == PH_RDY);
    // Drive enable covers a whole read access and drops once it is idle.
    assign bus_oe  = (phase != PH_IDLE) && !wr_q;
    // Read data only in read ready cycles.
    assign bus_out = (rdy && !wr_q) ? rdata : '0;

endmodule

// File: rtl/mpxt_target_chk.sv
// Protocol checker for mpxt_target, attached by bind. Watches ports and
// the controller state; adds no logic to the design.
module mpxt_target_chk #(
    parameter int LOC_W  = 8,
    parameter int OFF_HI = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              start_n,
    input logic              rdy,
    input logic              bus_oe,
    input mpxt_pkg::phase_t  phase,
    input logic [LOC_W-1:0]  addr_q,
    input logic              wr_q,
    input logic              last_q
);
    import mpxt_pkg::*;

    // R2: without a selected strobe the idle target stays idle.
    assert_ignore_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && (cs_n || start_n)) |=> (phase == PH_IDLE));

    // R3: a ready cycle is never followed by another ready cycle.
    assert_single_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);

    // R3: a wait cycle is always followed by ready.
    assert_wait_then_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT) |=> rdy);

    // R6: read ready cycles have the drive enable up.
    assert_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !wr_q) |-> bus_oe);

    // R6 and R7: after the final ready the lines are released and ready stays low.
    assert_release_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && last_q) |=> (!bus_oe && !rdy));

    // R8: a selected strobe in idle always opens an access.
    assert_accept_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !cs_n && !start_n) |=> (phase == PH_WAIT));

    // R9: between beats the word offset steps by one inside the block.
    assert_wrap_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !last_q) |=>
            (addr_q[LOC_W-1:OFF_HI+1] == $past(addr_q[LOC_W-1:OFF_HI+1]) &&
             addr_q[OFF_HI:2] == $past(addr_q[OFF_HI:2]) + 1'b1 &&
             addr_q[1:0] == $past(addr_q[1:0])));

endmodule

bind mpxt_target mpxt_target_chk #(
    .LOC_W  (LOC_W),
    .OFF_HI ($clog2(BLOCK_BYTES) - 1)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .start_n (start_n),
    .rdy     (rdy),
    .bus_oe  (bus_oe),
    .phase   (phase),
    .addr_q  (addr_q),
    .wr_q    (wr_q),
    .last_q  (last_q)
);

// File: tb/test_mpxt_target.sv
// Bench for mpxt_target: directed corner cases plus seeded random accesses,
// compared at falling edges against a bench-side word model.
module test_mpxt_target;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        start_n = 1'b1;
    logic        frame = 1'b0;
    logic        dir_wr = 1'b0;
    logic [31:0] bus_in = '0;
    logic [31:0] bus_out;
    logic        bus_oe;
    logic        rdy;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;
    bit          done = 1'b0;
    logic [31:0] model [64];
    logic [31:0] last_rd;

    always #10 clk = ~clk;

    mpxt_target i_mpxt_target (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .start_n (start_n),
        .frame   (frame),
        .dir_wr  (dir_wr),
        .bus_in  (bus_in),
        .bus_out (bus_out),
        .bus_oe  (bus_oe),
        .rdy     (rdy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Address of beat b: offset bits 4..2 advance modulo 8 (R9, R10).
    function automatic logic [31:0] beat_addr(input logic [31:0] a, input int b);
        logic [2:0] off;
        off = a[4:2] + 3'(b);
        return {a[31:5], off, a[1:0]};
    endfunction

    // Lane mask from size and low address bits (R5).
    function automatic logic [3:0] lanes(input logic [2:0] sz, input logic [1:0] lo);
        if (sz == 3'b000) return 4'b0001 << lo;
        if (sz == 3'b001) return lo[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] m);
        logic [31:0] r;
        for (int l = 0; l < 4; l++) r[l*8 +: 8] = m[l] ? nw[l*8 +: 8] : old[l*8 +: 8];
        return r;
    endfunction

    // One access; the first cycle is also the check that the previous access ended.
    task automatic access(input bit w, input logic [2:0] sz, input logic [31:0] a,
                          input int nb, input logic [31:0] d0, input string tag);
        logic [31:0] cur;
        logic [31:0] wd;
        @(negedge clk);
        check(rdy == 1'b0 && bus_oe == 1'b0, "R7", {30'b0, rdy, bus_oe}, 32'h0);
        cs_n    = 1'b0;
        start_n = 1'b0;
        frame   = 1'b1;
        dir_wr  = w;
        bus_in  = {sz, 3'b000, a[25:0]};
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            start_n = 1'b1;
            frame   = (b == nb - 1) ? 1'b0 : 1'b1;
            bus_in  = $urandom;
            check(rdy == 1'b0, "R3", {31'b0, rdy}, 32'h0);
            cur = beat_addr(a, b);
            wd  = d0 ^ (32'h1111_1111 * 32'(b));
            @(negedge clk);
            check(rdy == 1'b1, "R3", {31'b0, rdy}, 32'h1);
            if (w) begin
                check(bus_oe == 1'b0, "R6", {31'b0, bus_oe}, 32'h0);
                bus_in = wd;
                model[cur[7:2]] = merge(model[cur[7:2]], wd, lanes(sz, cur[1:0]));
            end else begin
                check(bus_oe == 1'b1, "R6", {31'b0, bus_oe}, 32'h1);
                check(bus_out == model[cur[7:2]], tag, bus_out, model[cur[7:2]]);
                last_rd = bus_out;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cs_n = 1'b1; start_n = 1'b1; frame = 1'b0; bus_in = $urandom;
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle after reset.
        check(rdy == 1'b0 && bus_oe == 1'b0 && bus_out == 32'h0, "R1",
              {bus_out[29:0], rdy, bus_oe}, 32'h0);
        // R1: every word reads zero (eight back-to-back bursts, R9 order).
        for (int k = 0; k < 8; k++) access(1'b0, 3'b100, 32'(k * 32 + 12), 8, 32'h0, "R1");

        // R2: strobe with chip select high is ignored.
        @(negedge clk);
        cs_n = 1'b1; start_n = 1'b0; frame = 1'b1; dir_wr = 1'b1; bus_in = 32'h4000_0000;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            start_n = 1'b1; frame = (i == 0); bus_in = 32'hDEAD_BEEF;
            check(rdy == 1'b0, "R2", {31'b0, rdy}, 32'h0);
        end
        idle(1);
        access(1'b0, 3'b010, 32'h0, 1, 32'h0, "R2");
        check(last_rd == 32'h0, "R2", last_rd, 32'h0);

        // R5: lane masking with literal expectations.
        access(1'b1, 3'b010, 32'h0C, 1, 32'hFFFF_FFFF, "R5");
        access(1'b1, 3'b000, 32'h0D, 1, 32'h0000_AA00, "R5");
        access(1'b1, 3'b001, 32'h0E, 1, 32'h1234_0000, "R5");
        access(1'b0, 3'b010, 32'h0C, 1, 32'h0, "R5");
        check(last_rd == 32'h1234_AAFF, "R5", last_rd, 32'h1234_AAFF);

        // R4: upper address bits alias onto the same word.
        access(1'b1, 3'b010, 32'h03FF_FF04, 1, 32'hCAFE_F00D, "R4");
        access(1'b0, 3'b010, 32'h0000_0004, 1, 32'h0, "R4");
        check(last_rd == 32'hCAFE_F00D, "R4", last_rd, 32'hCAFE_F00D);

        // R9: wrapped burst write from mid-block, read back from block start.
        access(1'b1, 3'b111, 32'h74, 8, 32'h5A5A_0000, "R9");
        access(1'b0, 3'b100, 32'h60, 8, 32'h0, "R9");
        // R10: quadword at the last word of a block wraps to its first word.
        access(1'b1, 3'b011, 32'h9C, 2, 32'h0BAD_0001, "R10");
        access(1'b0, 3'b010, 32'h80, 1, 32'h0, "R10");
        check(last_rd == (32'h0BAD_0001 ^ 32'h1111_1111), "R10", last_rd, 32'h0BAD_0001 ^ 32'h1111_1111);

        // R7: burst code cut short by frame after three beats; R8 next strobe at once.
        access(1'b1, 3'b100, 32'hA0, 3, 32'h7700_0000, "R7");
        access(1'b0, 3'b100, 32'hA0, 8, 32'h0, "R8");

        // Random mix, sometimes back-to-back, sometimes with idle gaps.
        for (int n = 0; n < 300; n++) begin
            logic [2:0]  sz;
            int          nb;
            int unsigned pick;
            pick = $urandom % 5;
            sz = (pick == 4) ? {1'b1, 2'($urandom)} : 3'(pick);
            nb = sz[2] ? 8 : (sz == 3'b011 ? 2 : 1);
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
            access(1'($urandom), sz, $urandom, nb, $urandom, "R6");
        end
        idle(1);
        check(rdy == 1'b0 && bus_oe == 1'b0, "R7", {30'b0, rdy, bus_oe}, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule